// File: doc/BRIEF.md
# Folded Column Decimation Filter

This block is the vertical half of a separable two-dimensional wavelet analysis. It takes a stream that has already been filtered along rows, arriving in raster order, and filters it down each column. It keeps one output row for every pair of input rows. Each output sample is the weighted sum of the same column in the current odd row and in the rows above it.

The taps are folded in pairs. One multiply-add unit serves two coefficients. On an even row it uses one coefficient of its pair and saves a partial sum for every column. On the following odd row it uses the other coefficient and completes that sum. The per-column partial sums sit in a line delay, one per multiply-add unit. The line delay is a circular buffer. Its length follows a level select, so the same hardware can filter the band of each decomposition level in turn. The level-1 band rows are `MAX_ROW` samples long, and each deeper level halves that length.

Top module: `colfold_filter`

## Requirements
- R1: While reset is held and after it is released, `outValid` is 0 and `outData` is 0 until the first output is produced.
- R2: Rows are counted from 0 at the frame start. For output row m and column c, `outData` equals c0·x(2m+1,c) + c1·x(2m,c) + c2·x(2m−1,c) + c3·x(2m−2,c). Here x(r,c) is the signed input in row r and column c, and ck is bits [8k+7:8k] of `COEFS` as a signed byte.
- R3: An input sample on an even row (0, 2, …) never raises `outValid`. Each valid sample on an odd row raises `outValid` for exactly one cycle, one clock after it is captured.
- R4: A valid sample with `frameStart` high makes that row row 0, which is even, whatever parity the previous row had. Rows from before the frame start contribute nothing to any result of the new frame.
- R5: The row length is `MAX_ROW >> level`. Level codes beyond `NUM_LEVELS-1` act as the last level. The column position is set to 0 by `rowStart`, and it also wraps to 0 when it reaches the row length.
- R6: Cycles with `inValid` low change no state and produce no output. Inserting idle cycles anywhere leaves the results unchanged.
- R7: `outData` keeps its last value in every cycle where `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample qualifier |
| inData | input | DATA_W | Row-filtered sample, signed |
| rowStart | input | 1 | Marks the first sample of a row |
| frameStart | input | 1 | Marks the first sample of a band; use together with rowStart |
| level | input | LVL_W | Decomposition level; selects the row length |
| outValid | output | 1 | Output sample qualifier |
| outData | output | ACC_W | Column-filtered sample, signed |

## Verification
The bench builds the block with 8-bit samples and coefficients, four taps, a 16-sample maximum row and three levels. With this setup it can sweep rows of 16, 8 and 4 samples, plus a level code that is out of range, in only a few hundred cycles. Every column of every row is checked against sums the bench computes itself. The frames use ramp data, pseudo-random data and full-scale alternating extremes. Some frames have idle gaps, and one frame has an odd number of rows, so the restart of parity and history is exercised as well.

// File: rtl/vdf_pkg.sv
package vdf_pkg;

  // strobes from the row/column sequencer to the multiply-add datapath
  typedef struct packed {
    logic wrEn;     // capture this sample into the line delays
    logic oddRow;   // second phase of the coefficient pair
    logic cutLink;  // first row pair of a frame: neighbour partial sums are void
    logic emit;     // completed output sample this cycle
  } vdf_strobe_t;

  function automatic int unsigned clog2c(input int unsigned v);
    int unsigned r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/vdf_ctrl.sv
module vdf_ctrl
  import vdf_pkg::*;
#(
  parameter int MAX_ROW    = 16,
  parameter int NUM_LEVELS = 3,
  localparam int ADDR_W    = clog2c(MAX_ROW),
  localparam int LVL_W     = clog2c(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              rowStart,
  input  logic              frameStart,
  input  logic [LVL_W-1:0]  level,
  output vdf_strobe_t       stb,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W:0]  ROW_MAX  = (ADDR_W + 1)'(MAX_ROW);
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(NUM_LEVELS - 1);
  localparam logic [ADDR_W:0]  ONE      = (ADDR_W + 1)'(1);

  logic [ADDR_W:0]  colReg, curCol, colInc, rowLen;
  logic [LVL_W-1:0] lvlEff;
  logic             oddReg, firstReg, curOdd, curFirst;

  // row length for the selected level, deeper codes clamp to the last level
  always_comb begin
    lvlEff = (level > LVL_LAST) ? LVL_LAST : level;
    rowLen = ROW_MAX >> lvlEff;
  end

  // position and phase of the sample presented this cycle
  always_comb begin
    curCol   = (rowStart || frameStart || colReg >= rowLen) ? '0 : colReg;
    curOdd   = frameStart ? 1'b0 : (rowStart ? ~oddReg : oddReg);
    curFirst = frameStart ? 1'b1 : ((rowStart && oddReg) ? 1'b0 : firstReg);
    colInc   = curCol + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colReg   <= '0;
      oddReg   <= 1'b0;
      firstReg <= 1'b1;
    end else if (inValid) begin
      colReg   <= (colInc >= rowLen) ? '0 : colInc;
      oddReg   <= curOdd;
      firstReg <= curFirst;
    end
  end

  always_comb begin
    stb.wrEn    = inValid;
    stb.oddRow  = curOdd;
    stb.cutLink = curFirst;
    stb.emit    = inValid & curOdd;
    addr        = curCol[ADDR_W-1:0];
  end

  // a frame start always opens an even row
  AST_FRAME_EVEN: assert property (@(posedge clk) disable iff (rst)
    (inValid && frameStart) |=> (oddReg == 1'b0)) else $error("frame start parity"); // R4

endmodule

// File: rtl/vdf_line_delay.sv
module vdf_line_delay #(
  parameter int WIDTH  = 18,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = vdf_pkg::clog2c(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  // read of the old column value and write of the new one share the address
  assign rdData = mem[addr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wrData;
  end

endmodule

// File: rtl/vdf_datapath.sv
module vdf_datapath
  import vdf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COEF_W  = 8,
  parameter int TAPS    = 4,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0,
  parameter int MAX_ROW = 16,
  localparam int NPE    = TAPS / 2,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + clog2c(TAPS),
  localparam int ADDR_W = clog2c(MAX_ROW)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] inData,
  input  vdf_strobe_t              stb,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);

  logic signed [ACC_W-1:0] rd   [NPE];
  logic signed [ACC_W-1:0] link [NPE];
  logic signed [ACC_W-1:0] sum  [NPE];

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    localparam logic signed [COEF_W-1:0] C_ODD_ROW  = COEFS[(2*i)*COEF_W +: COEF_W];
    localparam logic signed [COEF_W-1:0] C_EVEN_ROW = COEFS[(2*i+1)*COEF_W +: COEF_W];

    logic signed [COEF_W-1:0] coefSel;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         rdRaw;

    // partial sum handed over from the next element, void in the first row pair
    if (i == NPE - 1) begin : g_tail
      assign link[i] = '0;
    end else begin : g_chain
      assign link[i] = stb.cutLink ? '0 : rd[i+1];
    end

    // one shared multiplier and adder per coefficient pair
    always_comb begin
      coefSel = stb.oddRow ? C_ODD_ROW : C_EVEN_ROW;
      prod    = inData * coefSel;
      sum[i]  = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod} + (stb.oddRow ? rd[i] : link[i]);
    end

    vdf_line_delay #(.WIDTH(ACC_W), .DEPTH(MAX_ROW)) u_dly (
      .clk    (clk),
      .wrEn   (stb.wrEn),
      .addr   (addr),
      .wrData (sum[i]),
      .rdData (rdRaw)
    );
    assign rd[i] = $signed(rdRaw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= stb.emit;
      if (stb.emit) outData <= sum[0];
    end
  end

endmodule

// File: rtl/colfold_filter.sv
module colfold_filter
  import vdf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int COEF_W     = 8,
  parameter int TAPS       = 4,
  parameter logic [TAPS*COEF_W-1:0] COEFS = 32'h0207FB03,
  parameter int MAX_ROW    = 16,
  parameter int NUM_LEVELS = 3,
  localparam int LVL_W     = clog2c(NUM_LEVELS),
  localparam int ADDR_W    = clog2c(MAX_ROW),
  localparam int ACC_W     = DATA_W + COEF_W + clog2c(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     rowStart,
  input  logic                     frameStart,
  input  logic [LVL_W-1:0]         level,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);

  vdf_strobe_t       stb;
  logic [ADDR_W-1:0] addr;

  vdf_ctrl #(.MAX_ROW(MAX_ROW), .NUM_LEVELS(NUM_LEVELS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .rowStart   (rowStart),
    .frameStart (frameStart),
    .level      (level),
    .stb        (stb),
    .addr       (addr)
  );

  vdf_datapath #(
    .DATA_W (DATA_W), .COEF_W (COEF_W), .TAPS (TAPS),
    .COEFS  (COEFS),  .MAX_ROW(MAX_ROW)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inData   (inData),
    .stb      (stb),
    .addr     (addr),
    .outValid (outValid),
    .outData  (outData)
  );

  AST_OUT_AFTER_INPUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid)) else $error("output without input"); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid) else $error("output after idle cycle"); // R6
  AST_EVEN_NO_EMIT: assert property (@(posedge clk) disable iff (rst)
    (inValid && !stb.oddRow) |=> !outValid) else $error("output on even row"); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData)) else $error("output moved while invalid"); // R7

endmodule

// File: tb/sim_colfold_filter.sv
module sim_colfold_filter;

  localparam int DW = 8;
  localparam int AW = 18;
  localparam int C0 = 3, C1 = -5, C2 = 7, C3 = 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] inData = '0;
  logic                 rowStart = 1'b0;
  logic                 frameStart = 1'b0;
  logic [1:0]           level = '0;
  logic                 outValid;
  logic signed [AW-1:0] outData;

  always #10 clk = ~clk;

  colfold_filter #(
    .DATA_W(8), .COEF_W(8), .TAPS(4), .COEFS(32'h0207FB03),
    .MAX_ROW(16), .NUM_LEVELS(3)
  ) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .rowStart(rowStart), .frameStart(frameStart), .level(level),
    .outValid(outValid), .outData(outData)
  );

  int errors = 0;
  int checks = 0;
  int seed   = 32'h1234;
  int fx [8][16];

  // what the driver presented in the current cycle, and its one-cycle-old copy
  bit    drvValid = 0, drvOdd = 0, pValid = 0, pOdd = 0, monOn = 0;
  int    drvExp = 0, pExp = 0, lastOut = 0;
  string drvTag = "R2", pTag = "R2";

  function automatic int lcg();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 255) - 128;
  endfunction

  task automatic idle();
    @(posedge clk); #1;
    inValid = 0; rowStart = 0; frameStart = 0;
    inData = DW'(lcg());
    drvValid = 0; drvOdd = 0;
  endtask

  task automatic sendFrame(int lvl, int rows, int mode, int gapEvery, string tag);
    int len;
    len = 16 >> ((lvl > 2) ? 2 : lvl);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < len; c++) begin
        int x, y;
        if (mode == 0)      x = r * 16 + c - 60;
        else if (mode == 1) x = lcg();
        else                x = ((r + c) % 2 == 1) ? 127 : -128;
        fx[r][c] = x;
        if (gapEvery > 0 && ((r * len + c) % gapEvery) == gapEvery - 1) idle();
        y = C0 * fx[r][c];
        if (r >= 1) y += C1 * fx[r-1][c];
        if (r >= 2) y += C2 * fx[r-2][c];
        if (r >= 3) y += C3 * fx[r-3][c];
        @(posedge clk); #1;
        inValid = 1; inData = DW'(x); level = 2'(lvl);
        rowStart = (c == 0); frameStart = (r == 0 && c == 0);
        drvValid = 1; drvOdd = (r % 2 == 1); drvExp = y;
        drvTag = (r < 3 && tag == "R4") ? "R4" : tag;
      end
    end
    idle();
  endtask

  // checks one cycle after capture, away from the clock edge
  always @(negedge clk) begin
    if (monOn) begin
      bit expV;
      expV = pValid && pOdd;
      checks++;
      if (outValid !== expV) begin
        errors++;
        $display("FAIL %s: outValid=%0b expected %0b", pValid ? "R3" : "R6", outValid, expV);
      end else if (expV) begin
        if (int'(outData) != pExp) begin
          errors++;
          $display("FAIL %s: outData=%0d expected %0d", pTag, int'(outData), pExp);
        end
        lastOut = int'(outData);
      end else if (int'(outData) != lastOut) begin
        errors++;
        $display("FAIL R7: outData=%0d expected held %0d", int'(outData), lastOut);
      end
    end
    pValid = drvValid; pOdd = drvOdd; pExp = drvExp; pTag = drvTag;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      errors++;
      $display("FAIL R1: outValid=%0b outData=%0d expected 0 0", outValid, outData);
    end
    @(posedge clk); #1; rst = 0;
    monOn = 1;
    idle(); idle();
    sendFrame(0, 6, 0, 0, "R2");   // R2 ramp at full row length
    sendFrame(1, 6, 1, 3, "R5");   // R5 half rows, R6 idle gaps
    sendFrame(2, 8, 2, 0, "R5");   // R5 quarter rows, full-scale extremes
    sendFrame(1, 5, 1, 0, "R4");   // odd row count ...
    sendFrame(1, 4, 1, 0, "R4");   // ... then R4 restart of parity and history
    sendFrame(0, 4, 1, 2, "R2");   // R2 with dense gaps
    sendFrame(3, 4, 1, 0, "R5");   // R5 out-of-range level acts as last level
    idle(); idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule